// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is the small byte-wide control corner of a workstation I/O companion device. A host issues single-cycle reads and writes on a flat address bus. The block keeps a handful of control bytes: configuration, diagnostic, modem control, a miscellaneous-function byte and a software power-down byte. It also keeps one 32-bit system control word. Its outputs are the stored bytes, a power-fail interrupt line and three one-clock command strobes. The strobes request a floppy terminal count, a power-off and a system reset.

The power-down byte is not a plain store. Software may set only its two command bits. The power-fail status bit inside it is sticky. It is driven by an external power-failing level together with an enable bit in the configuration byte, and software clears it by writing a one to the interrupt-clear bit. There are two reset inputs. The ordinary block reset leaves the diagnostic byte and the system control word alone, so a reset the system itself requested can still be seen after it happens. A power-on reset clears everything.

Top module: `aux_sysctl_regs`

## Requirements
- R1: The register is chosen by `bus_addr & 32'h0FFF0000`. The regions are: configuration at 0x01800000, diagnostic at 0x01A00000, modem control at 0x01B00000, miscellaneous byte at 0x01900000, power-down byte at 0x01D00000 and system control at 0x01F00000. Address bits outside the mask do not affect the choice.
- R2: `pwr_irq` is high exactly when power-down bit 5 (power-fail) and configuration bit 3 (power interrupt enable) are both set. It follows every change of either bit in the same clock edge.
- R3: In a cycle where `pwr_fail_in` differs from its value in the previous cycle, power-down bit 5 takes `pwr_fail_in AND` configuration bit 3. Bit 3 is taken as it stands after that cycle's writes. In every other cycle bit 5 holds its value. The block resets treat the previous input value as low.
- R4: A write to the power-down byte stores only data bits 1:0. Bits 7:6 and 4:2 always read zero. Bit 5 is kept unless data bit 1 is set, in which case bit 5 is cleared; this clear wins over an R3 set in the same cycle. Data bit 0 gives a one-cycle `poweroff_req` pulse after the write edge.
- R5: A write to the miscellaneous byte stores data bits 7:0. If data bit 1 (terminal count) is set, `fd_tc_pulse` is high for exactly the one cycle after the write edge.
- R6: A write to the system control region with data bit 0 set loads the word with 0x00000002 and gives a one-cycle `sys_reset_req` pulse. A write there with bit 0 clear changes nothing.
- R7: The configuration, diagnostic and modem control registers each store data bits 7:0 on a write. Each one drives its own output port.
- R8: While `rst` is high, the configuration, miscellaneous, power-down and modem bytes, the strobes, `pwr_irq` and `bus_rdata` are cleared and writes are ignored. The diagnostic byte and the system control word keep their values.
- R9: While `por_rst` is high, every register, including the diagnostic byte and the system control word, is cleared.
- R10: `bus_rdata` is registered. In the cycle after `bus_rd` it shows the selected register as it was before any write in that same cycle, with bytes zero-extended. In the cycle after a cycle without `bus_rd`, it is zero.
- R11: Reads of the LED region (0x01600000) or any unlisted region return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 32 | Host byte address |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwr_fail_in | input | 1 | Power-failing level from the supply monitor |
| pwr_irq | output | 1 | Power-fail interrupt |
| fd_tc_pulse | output | 1 | Floppy terminal-count strobe |
| poweroff_req | output | 1 | Software power-off request strobe |
| sys_reset_req | output | 1 | System reset request strobe |
| cfg_out | output | 8 | Configuration byte |
| diag_out | output | 8 | Diagnostic byte |
| modem_ctl | output | 8 | Modem control byte |
| aux1_out | output | 8 | Miscellaneous-function byte |

## Verification
Some properties are checked on every cycle. The interrupt must match the AND of the power-fail bit and the enable. The power-fail bit may rise only while the enable is set. The dead bits of the power-down byte must stay at zero. Each strobe must follow the write that caused it, and the system control word must be 0x2 whenever a reset request fires. Read data must return to zero after an idle cycle, and the two reset scopes must hold (diagnostic and system word kept, the other bytes cleared). Some behaviour only the bench scenarios can show. These are the edge-only sampling of the power input, the clear winning over a set in the same cycle, read-before-write ordering, decode that ignores address bits outside the mask, and writes to unmapped or LED regions leaving every register unchanged.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [31:0] DEF_REG_MASK  = 32'h0FFF_0000;
  localparam logic [31:0] DEF_OFS_LED   = 32'h0160_0000;
  localparam logic [31:0] DEF_OFS_CFG   = 32'h0180_0000;
  localparam logic [31:0] DEF_OFS_AUX1  = 32'h0190_0000;
  localparam logic [31:0] DEF_OFS_DIAG  = 32'h01A0_0000;
  localparam logic [31:0] DEF_OFS_MDM   = 32'h01B0_0000;
  localparam logic [31:0] DEF_OFS_AUX2  = 32'h01D0_0000;
  localparam logic [31:0] DEF_OFS_SYS   = 32'h01F0_0000;

  // bit positions
  localparam int unsigned CFG_PIE_BIT   = 3;
  localparam int unsigned AUX2_OFF_BIT  = 0;
  localparam int unsigned AUX2_CLR_BIT  = 1;
  localparam int unsigned AUX2_PF_BIT   = 5;
  localparam int unsigned AUX1_TC_BIT   = 1;
  localparam int unsigned SYS_REQ_BIT   = 0;
  localparam logic [31:0] SYS_RSTSTAT   = 32'h0000_0002;

  // byte bank slots
  localparam int unsigned SLOT_CFG  = 0;
  localparam int unsigned SLOT_DIAG = 1;
  localparam int unsigned SLOT_MDM  = 2;
  localparam int unsigned N_SLOTS   = 3;
  localparam logic [N_SLOTS-1:0] SLOT_KEEP_ON_RST = 3'b010;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CFG,
    RG_DIAG,
    RG_MDM,
    RG_AUX1,
    RG_AUX2,
    RG_SYS,
    RG_LED
  } region_e;

endpackage

// File: rtl/aux_sysctl_decode.sv
module aux_sysctl_decode
  import aux_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] REG_MASK = ADDR_W'(DEF_REG_MASK),
  parameter logic [ADDR_W-1:0] OFS_LED  = ADDR_W'(DEF_OFS_LED),
  parameter logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(DEF_OFS_CFG),
  parameter logic [ADDR_W-1:0] OFS_AUX1 = ADDR_W'(DEF_OFS_AUX1),
  parameter logic [ADDR_W-1:0] OFS_DIAG = ADDR_W'(DEF_OFS_DIAG),
  parameter logic [ADDR_W-1:0] OFS_MDM  = ADDR_W'(DEF_OFS_MDM),
  parameter logic [ADDR_W-1:0] OFS_AUX2 = ADDR_W'(DEF_OFS_AUX2),
  parameter logic [ADDR_W-1:0] OFS_SYS  = ADDR_W'(DEF_OFS_SYS)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = addr & REG_MASK;
    if      (masked == OFS_CFG)  region = RG_CFG;
    else if (masked == OFS_DIAG) region = RG_DIAG;
    else if (masked == OFS_MDM)  region = RG_MDM;
    else if (masked == OFS_AUX1) region = RG_AUX1;
    else if (masked == OFS_AUX2) region = RG_AUX2;
    else if (masked == OFS_SYS)  region = RG_SYS;
    else if (masked == OFS_LED)  region = RG_LED;
    else                         region = RG_NONE;
  end

endmodule

// File: rtl/aux_sysctl_bytebank.sv
module aux_sysctl_bytebank
  import aux_sysctl_pkg::*;
#(
  parameter int unsigned N_REGS = N_SLOTS,
  parameter int unsigned W      = BYTE_W,
  parameter logic [N_REGS-1:0] KEEP_ON_RST = SLOT_KEEP_ON_RST
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  por_rst,
  input  logic [N_REGS-1:0]     wr_sel,
  input  logic [W-1:0]          wbyte,
  output logic [N_REGS-1:0][W-1:0] q
);

  for (genvar i = 0; i < N_REGS; i++) begin : g_slot
    if (KEEP_ON_RST[i]) begin : g_keep
      always_ff @(posedge clk) begin
        if (por_rst)                q[i] <= '0;
        else if (!rst && wr_sel[i]) q[i] <= wbyte;
      end
    end else begin : g_clear
      always_ff @(posedge clk) begin
        if (por_rst || rst)  q[i] <= '0;
        else if (wr_sel[i])  q[i] <= wbyte;
      end
    end
  end

endmodule

// File: rtl/aux_sysctl_pwr.sv
module aux_sysctl_pwr
  import aux_sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              por_rst,
  input  logic              pwr_fail_in,
  input  logic              en_next,
  input  logic              wr_aux2,
  input  logic [1:0]        wbits,
  output logic [BYTE_W-1:0] aux2_q,
  output logic              irq_q,
  output logic              off_q
);

  logic       prev_q;
  logic       pf_q;
  logic [1:0] cmd_q;
  logic       pf_n;
  logic [1:0] cmd_n;

  always_comb begin
    pf_n = pf_q;
    if (pwr_fail_in != prev_q) pf_n = pwr_fail_in & en_next;
    if (wr_aux2 && wbits[AUX2_CLR_BIT]) pf_n = 1'b0;
    cmd_n = wr_aux2 ? wbits : cmd_q;
  end

  always_ff @(posedge clk) begin
    if (por_rst || rst) begin
      prev_q <= 1'b0;
      pf_q   <= 1'b0;
      cmd_q  <= '0;
      irq_q  <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      prev_q <= pwr_fail_in;
      pf_q   <= pf_n;
      cmd_q  <= cmd_n;
      irq_q  <= pf_n & en_next;
      off_q  <= wr_aux2 & wbits[AUX2_OFF_BIT];
    end
  end

  always_comb begin
    aux2_q = '0;
    aux2_q[AUX2_PF_BIT]  = pf_q;
    aux2_q[AUX2_CLR_BIT] = cmd_q[AUX2_CLR_BIT];
    aux2_q[AUX2_OFF_BIT] = cmd_q[AUX2_OFF_BIT];
  end

endmodule

// File: rtl/aux_sysctl_ctl.sv
module aux_sysctl_ctl
  import aux_sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_rst,
  input  logic              wr_aux1,
  input  logic              wr_sys,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] aux1_q,
  output logic [DATA_W-1:0] sys_q,
  output logic              tc_q,
  output logic              srst_q
);

  always_ff @(posedge clk) begin
    if (por_rst) begin
      aux1_q <= '0;
      tc_q   <= 1'b0;
      srst_q <= 1'b0;
      sys_q  <= '0;
    end else if (rst) begin
      aux1_q <= '0;
      tc_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      tc_q   <= wr_aux1 & wbyte[AUX1_TC_BIT];
      srst_q <= wr_sys & wbyte[SYS_REQ_BIT];
      if (wr_aux1) aux1_q <= wbyte;
      if (wr_sys && wbyte[SYS_REQ_BIT]) sys_q <= DATA_W'(SYS_RSTSTAT);
    end
  end

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_MASK = ADDR_W'(DEF_REG_MASK),
  parameter logic [ADDR_W-1:0] OFS_AUX1 = ADDR_W'(DEF_OFS_AUX1),
  parameter logic [ADDR_W-1:0] OFS_AUX2 = ADDR_W'(DEF_OFS_AUX2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_fail_in,
  output logic              pwr_irq,
  output logic              fd_tc_pulse,
  output logic              poweroff_req,
  output logic              sys_reset_req,
  output logic [BYTE_W-1:0] cfg_out,
  output logic [BYTE_W-1:0] diag_out,
  output logic [BYTE_W-1:0] modem_ctl,
  output logic [BYTE_W-1:0] aux1_out
);

  localparam int unsigned PAD_W = DATA_W - BYTE_W;

  region_e                      region;
  logic [BYTE_W-1:0]            wbyte;
  logic [N_SLOTS-1:0]           bank_sel;
  logic [N_SLOTS-1:0][BYTE_W-1:0] bank_q;
  logic [BYTE_W-1:0]            aux2_q;
  logic [DATA_W-1:0]            sys_q;
  logic                         en_next;
  logic [DATA_W-1:0]            rd_mux;
  logic                         unused_wdata_hi;

  assign wbyte           = bus_wdata[BYTE_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BYTE_W];

  aux_sysctl_decode #(
    .ADDR_W   (ADDR_W),
    .REG_MASK (REG_MASK),
    .OFS_AUX1 (OFS_AUX1),
    .OFS_AUX2 (OFS_AUX2)
  ) u_decode (
    .addr   (bus_addr),
    .region (region)
  );

  always_comb begin
    bank_sel            = '0;
    bank_sel[SLOT_CFG]  = bus_wr && (region == RG_CFG);
    bank_sel[SLOT_DIAG] = bus_wr && (region == RG_DIAG);
    bank_sel[SLOT_MDM]  = bus_wr && (region == RG_MDM);
  end

  aux_sysctl_bytebank #(
    .N_REGS      (N_SLOTS),
    .W           (BYTE_W),
    .KEEP_ON_RST (SLOT_KEEP_ON_RST)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .por_rst (por_rst),
    .wr_sel  (bank_sel),
    .wbyte   (wbyte),
    .q       (bank_q)
  );

  assign cfg_out   = bank_q[SLOT_CFG];
  assign diag_out  = bank_q[SLOT_DIAG];
  assign modem_ctl = bank_q[SLOT_MDM];

  // enable bit as it stands after this cycle's write
  assign en_next = bank_sel[SLOT_CFG] ? wbyte[CFG_PIE_BIT] : cfg_out[CFG_PIE_BIT];

  aux_sysctl_pwr u_pwr (
    .clk         (clk),
    .rst         (rst),
    .por_rst     (por_rst),
    .pwr_fail_in (pwr_fail_in),
    .en_next     (en_next),
    .wr_aux2     (bus_wr && (region == RG_AUX2)),
    .wbits       (wbyte[1:0]),
    .aux2_q      (aux2_q),
    .irq_q       (pwr_irq),
    .off_q       (poweroff_req)
  );

  aux_sysctl_ctl #(
    .DATA_W (DATA_W)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .por_rst (por_rst),
    .wr_aux1 (bus_wr && (region == RG_AUX1)),
    .wr_sys  (bus_wr && (region == RG_SYS)),
    .wbyte   (wbyte),
    .aux1_q  (aux1_out),
    .sys_q   (sys_q),
    .tc_q    (fd_tc_pulse),
    .srst_q  (sys_reset_req)
  );

  always_comb begin
    unique case (region)
      RG_CFG:  rd_mux = {{PAD_W{1'b0}}, cfg_out};
      RG_DIAG: rd_mux = {{PAD_W{1'b0}}, diag_out};
      RG_MDM:  rd_mux = {{PAD_W{1'b0}}, modem_ctl};
      RG_AUX1: rd_mux = {{PAD_W{1'b0}}, aux1_out};
      RG_AUX2: rd_mux = {{PAD_W{1'b0}}, aux2_q};
      RG_SYS:  rd_mux = sys_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_rst || rst)  bus_rdata <= '0;
    else if (bus_rd)     bus_rdata <= rd_mux;
    else                 bus_rdata <= '0;
  end

endmodule

// File: rtl/aux_sysctl_regs_chk.sv
module aux_sysctl_regs_chk
  import aux_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              por_rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pwr_irq,
  input logic              fd_tc_pulse,
  input logic              poweroff_req,
  input logic              sys_reset_req,
  input logic [BYTE_W-1:0] cfg_out,
  input logic [BYTE_W-1:0] diag_out,
  input logic [BYTE_W-1:0] aux1_out,
  input logic [BYTE_W-1:0] aux2_q,
  input logic [DATA_W-1:0] sys_q
);

  logic hit_aux1, hit_aux2;
  assign hit_aux1 = (bus_addr & ADDR_W'(DEF_REG_MASK)) == ADDR_W'(DEF_OFS_AUX1);
  assign hit_aux2 = (bus_addr & ADDR_W'(DEF_REG_MASK)) == ADDR_W'(DEF_OFS_AUX2);

  // R2
  a_r2_irq_is_and: assert property (@(posedge clk) disable iff (rst || por_rst)
    pwr_irq == (aux2_q[AUX2_PF_BIT] && cfg_out[CFG_PIE_BIT]));

  // R3
  a_r3_pf_rise_needs_en: assert property (@(posedge clk) disable iff (rst || por_rst)
    $rose(aux2_q[AUX2_PF_BIT]) |-> cfg_out[CFG_PIE_BIT]);

  // R4
  a_r4_dead_bits_zero: assert property (@(posedge clk) disable iff (por_rst)
    (aux2_q & 8'hDC) == 8'h00);

  // R4
  a_r4_off_follows_write: assert property (@(posedge clk) disable iff (por_rst)
    !$past(rst || por_rst) |-> (poweroff_req == $past(bus_wr && hit_aux2 && bus_wdata[0])));

  // R5
  a_r5_tc_follows_write: assert property (@(posedge clk) disable iff (por_rst)
    !$past(rst || por_rst) |-> (fd_tc_pulse == $past(bus_wr && hit_aux1 && bus_wdata[1])));

  // R6
  a_r6_req_means_status: assert property (@(posedge clk) disable iff (rst || por_rst)
    sys_reset_req |-> (sys_q == 32'h2));

  // R8
  a_r8_rst_keeps_diag_sys: assert property (@(posedge clk) disable iff (por_rst)
    ($past(rst) && !$past(por_rst)) |-> ($stable(diag_out) && $stable(sys_q)));

  // R8
  a_r8_rst_clears_rest: assert property (@(posedge clk) disable iff (por_rst)
    ($past(rst) && !$past(por_rst)) |->
      (cfg_out == 8'h0 && aux1_out == 8'h0 && aux2_q == 8'h0 && !pwr_irq));

  // R10
  a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (por_rst)
    !$past(bus_rd) |-> (bus_rdata == '0));

endmodule

bind aux_sysctl_regs aux_sysctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .por_rst       (por_rst),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .pwr_irq       (pwr_irq),
  .fd_tc_pulse   (fd_tc_pulse),
  .poweroff_req  (poweroff_req),
  .sys_reset_req (sys_reset_req),
  .cfg_out       (cfg_out),
  .diag_out      (diag_out),
  .aux1_out      (aux1_out),
  .aux2_q        (aux2_q),
  .sys_q         (sys_q)
);

// File: tb/aux_sysctl_regs_test.sv
module aux_sysctl_regs_test;

  localparam logic [31:0] A_LED  = 32'h0160_0000;
  localparam logic [31:0] A_CFG  = 32'h0180_0000;
  localparam logic [31:0] A_AUX1 = 32'h0190_0000;
  localparam logic [31:0] A_DIAG = 32'h01A0_0000;
  localparam logic [31:0] A_MDM  = 32'h01B0_0000;
  localparam logic [31:0] A_AUX2 = 32'h01D0_0000;
  localparam logic [31:0] A_SYS  = 32'h01F0_0000;
  localparam logic [31:0] A_NONE = 32'h0120_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por_rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_fail_in = 1'b0;
  logic        pwr_irq, fd_tc_pulse, poweroff_req, sys_reset_req;
  logic [7:0]  cfg_out, diag_out, modem_ctl, aux1_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  aux_sysctl_regs uut (
    .clk(clk), .rst(rst), .por_rst(por_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_fail_in(pwr_fail_in), .pwr_irq(pwr_irq),
    .fd_tc_pulse(fd_tc_pulse), .poweroff_req(poweroff_req),
    .sys_reset_req(sys_reset_req),
    .cfg_out(cfg_out), .diag_out(diag_out),
    .modem_ctl(modem_ctl), .aux1_out(aux1_out)
  );

  // ---------------- behavioural reference ----------------
  int          m_cfg, m_diag, m_mdm, m_aux1, m_aux2;
  logic [31:0] m_sys, m_rdata;
  bit          m_prev, m_irq, m_tc, m_off, m_srst;

  function automatic int which(input logic [31:0] a);
    logic [31:0] k;
    k = a & 32'h0FFF_0000;
    if (k == A_CFG)  return 1;
    if (k == A_DIAG) return 2;
    if (k == A_MDM)  return 3;
    if (k == A_AUX1) return 4;
    if (k == A_AUX2) return 5;
    if (k == A_SYS)  return 6;
    return 0;
  endfunction

  initial begin
    m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0;
    m_sys = 0; m_rdata = 0; m_prev = 0; m_irq = 0; m_tc = 0; m_off = 0; m_srst = 0;
  end

  always @(posedge clk) begin
    int r, wd;
    bit pf, en;
    r  = which(bus_addr);
    wd = int'(bus_wdata[7:0]);
    if (por_rst) begin
      m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0; m_sys = 0;
      m_rdata = 0; m_prev = 0; m_irq = 0; m_tc = 0; m_off = 0; m_srst = 0;
    end else if (rst) begin
      m_cfg = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0;
      m_rdata = 0; m_prev = 0; m_irq = 0; m_tc = 0; m_off = 0; m_srst = 0;
    end else begin
      m_rdata = 0;
      if (bus_rd) begin
        case (r)
          1: m_rdata = 32'(m_cfg);
          2: m_rdata = 32'(m_diag);
          3: m_rdata = 32'(m_mdm);
          4: m_rdata = 32'(m_aux1);
          5: m_rdata = 32'(m_aux2);
          6: m_rdata = m_sys;
          default: m_rdata = 0;
        endcase
      end
      m_tc = 0; m_off = 0; m_srst = 0;
      if (bus_wr) begin
        case (r)
          1: m_cfg = wd;
          2: m_diag = wd;
          3: m_mdm = wd;
          4: begin m_aux1 = wd; m_tc = (wd / 2) % 2 == 1; end
          6: if (wd % 2 == 1) begin m_sys = 2; m_srst = 1; end
          default: ;
        endcase
      end
      en = (m_cfg / 8) % 2 == 1;
      pf = (m_aux2 / 32) % 2 == 1;
      if (pwr_fail_in != m_prev) pf = pwr_fail_in && en;
      m_prev = pwr_fail_in;
      if (bus_wr && r == 5) begin
        if ((wd / 2) % 2 == 1) pf = 0;
        m_off  = wd % 2 == 1;
        m_aux2 = (pf ? 32 : 0) + (wd % 4);
      end else begin
        m_aux2 = (pf ? 32 : 0) + (m_aux2 % 4);
      end
      m_irq = pf && en;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R10 rdata",      bus_rdata, m_rdata);
    chk("R2 irq",         {31'b0, pwr_irq}, {31'b0, m_irq});
    chk("R5 tc",          {31'b0, fd_tc_pulse}, {31'b0, m_tc});
    chk("R4 poweroff",    {31'b0, poweroff_req}, {31'b0, m_off});
    chk("R6 sysreset",    {31'b0, sys_reset_req}, {31'b0, m_srst});
    chk("R7 cfg_out",     {24'b0, cfg_out}, 32'(m_cfg));
    chk("R7 diag_out",    {24'b0, diag_out}, 32'(m_diag));
    chk("R7 modem_ctl",   {24'b0, modem_ctl}, 32'(m_mdm));
    chk("R5 aux1_out",    {24'b0, aux1_out}, 32'(m_aux1));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) tick();
    por_rst = 1'b0;
    tick();
    rst = 1'b0;
    tick();
    // R9 reset state
    chk("R9 reset cfg", {24'b0, cfg_out}, 32'h0);
    rd(A_SYS, v);  chk("R9 reset sys", v, 32'h0);

    // R7 / R1 byte registers, with address bits outside the mask set
    wr(A_CFG  | 32'hF000_1234, 32'hFFFF_FF35);
    wr(A_DIAG | 32'h3000_00FF, 32'h0000_005A);
    wr(A_MDM,                  32'h0000_00C3);
    rd(A_CFG  | 32'h5000_0001, v); chk("R1 cfg decode", v, 32'h35);
    rd(A_DIAG, v);                 chk("R7 diag read", v, 32'h5A);
    rd(A_MDM  | 32'h0000_FFFF, v); chk("R1 mdm decode", v, 32'hC3);

    // R11 unmapped and LED regions
    wr(A_LED,  32'h0000_00EE);
    wr(A_NONE, 32'h0000_00EE);
    rd(A_LED, v);  chk("R11 led read", v, 32'h0);
    rd(A_NONE, v); chk("R11 none read", v, 32'h0);
    chk("R11 cfg untouched", {24'b0, cfg_out}, 32'h35);
    chk("R11 diag untouched", {24'b0, diag_out}, 32'h5A);

    // R10 read-before-write in the same cycle
    bus_addr = A_MDM; bus_wdata = 32'h11; bus_wr = 1'b1; bus_rd = 1'b1;
    tick();
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 old value", bus_rdata, 32'hC3);

    // R5 terminal count
    wr(A_AUX1, 32'h02);
    tick();
    wr(A_AUX1, 32'hFD);
    rd(A_AUX1, v); chk("R5 aux1 stored", v, 32'hFD);

    // R3 / R2 power fail
    wr(A_CFG, 32'h08);
    pwr_fail_in = 1'b1; tick();
    chk("R2 irq up", {31'b0, pwr_irq}, 32'h1);
    rd(A_AUX2, v); chk("R3 pf set", v, 32'h20);
    wr(A_CFG, 32'h00);
    chk("R2 irq drops with enable", {31'b0, pwr_irq}, 32'h0);
    wr(A_CFG, 32'h08);
    chk("R2 irq back", {31'b0, pwr_irq}, 32'h1);
    wr(A_AUX2, 32'h01);
    rd(A_AUX2, v); chk("R4 pf kept, off stored", v, 32'h21);
    wr(A_AUX2, 32'hFE);
    rd(A_AUX2, v); chk("R4 clear and mask", v, 32'h02);
    repeat (3) tick();
    rd(A_AUX2, v); chk("R3 level does not re-set", v, 32'h02);

    // R3 rise with enable off, then enable
    pwr_fail_in = 1'b0; tick();
    wr(A_CFG, 32'h00);
    pwr_fail_in = 1'b1; tick();
    wr(A_CFG, 32'h08);
    rd(A_AUX2, v); chk("R3 no set without enable", v, 32'h02);
    pwr_fail_in = 1'b0; tick();

    // R4 clear wins over same-cycle set
    bus_addr = A_AUX2; bus_wdata = 32'h02; bus_wr = 1'b1; pwr_fail_in = 1'b1;
    tick();
    bus_wr = 1'b0;
    rd(A_AUX2, v); chk("R4 clear wins", v, 32'h02);

    // R6 system control
    wr(A_SYS, 32'h0000_0004);
    rd(A_SYS, v); chk("R6 no bit0 no change", v, 32'h0);
    wr(A_SYS, 32'hFFFF_FFFF);
    rd(A_SYS, v); chk("R6 status", v, 32'h2);

    // R8 block reset
    rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
    rd(A_DIAG, v); chk("R8 diag kept", v, 32'h5A);
    rd(A_SYS, v);  chk("R8 sys kept", v, 32'h2);
    rd(A_CFG, v);  chk("R8 cfg cleared", v, 32'h0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pick;
      case ($urandom % 8)
        0: pick = A_CFG;  1: pick = A_DIAG; 2: pick = A_MDM;  3: pick = A_AUX1;
        4: pick = A_AUX2; 5: pick = A_SYS;  6: pick = A_LED;  default: pick = A_NONE;
      endcase
      bus_addr  = pick | ($urandom & 32'hF000_FFFF);
      bus_wdata = $urandom;
      bus_wr    = ($urandom % 3) == 0;
      bus_rd    = ($urandom % 2) == 0;
      if (($urandom % 5) == 0) pwr_fail_in = ~pwr_fail_in;
      rst       = ($urandom % 200) == 0;
      tick();
    end
    bus_wr = 1'b0; bus_rd = 1'b0; rst = 1'b0;
    tick();

    // R9 power-on reset clears diag and system control
    wr(A_DIAG, 32'h77);
    wr(A_SYS, 32'h1);
    por_rst = 1'b1; tick(); por_rst = 1'b0; tick();
    rd(A_DIAG, v); chk("R9 diag cleared", v, 32'h0);
    rd(A_SYS, v);  chk("R9 sys cleared", v, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule